// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits behind the control pins of an SDRAM-style memory device. On every rising clock it samples chip select, the row strobe, the column strobe, write enable, the bank-select bits and the address bus. It turns them into one decoded command and registers that command along with the fields that belong to it: the target bank, the auto-precharge flag, the column address, the mode-register selector and the opcode.

Alongside the decode it keeps an idle or active flag and an open-row register for each of four banks. It raises a sticky flag when the command stream breaks the bank protocol. When clock enable drops, it records whether the device enters precharge power-down or active power-down. Timing parameters, data transfers and the meaning of mode-register bits are left to other blocks.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: All outputs are registered and change only on a rising clock edge, one cycle after the inputs they reflect. After reset `cmd_o` is 0 (no operation), every bank is idle, every open row is 0, `violation_o` is 0 and `pd_mode_o` is 0.
- R2: When `cs_ni` is high at a clock edge with `cke_i` high, the command is a no-operation whatever the other strobes are, and no bank changes state.
- R3: With `cs_ni` low, the strobes {`ras_ni`,`cas_ni`,`we_ni`} decode as follows, and `cmd_o` reports each command as a code:

  | Strobes | Command | Code |
  |---|---|---|
  | 011 | activate | 1 |
  | 101 | read | 2 |
  | 100 | write | 3 |
  | 010 with `addr_i[10]`=0 | precharge one bank | 4 |
  | 010 with `addr_i[10]`=1 | precharge all banks | 5 |
  | 001 | refresh | 6 |
  | 000 | mode-register load | 7 |
  | 111 and 110 | no operation | 0 |

- R4: `bank_o` equals `ba_i` for activate, read, write and single-bank precharge, and is 0 for every other command.
- R5: Activate to an idle bank marks that bank active and stores `addr_i` as its open row. The open row appears in bits [13*b+12 : 13*b] of `open_row_o`.
- R6: Single-bank precharge makes only bank `ba_i` idle. Precharge-all makes every bank idle.
- R7: For read and write, `auto_pre_o` equals `addr_i[10]`, and `col_o` equals the address with bit 10 removed ({`addr_i[12:11]`,`addr_i[9:0]`}). `col_o` holds its value through other commands. A read or write with auto-precharge to an active bank returns that bank to idle. For every other command `auto_pre_o` is 0.
- R8: On a mode-register load, `opcode_o` takes `addr_i`, and `mrs_ext_o` becomes 1 when `ba_i` is 1 (extended register) and 0 otherwise. Both hold their values through all other commands.
- R9: Any of the following sets `violation_o`, which stays set until reset: an activate to an active bank, or a read or write to an idle bank. An illegal activate leaves the open row unchanged.
- R10: When `cke_i` is low at a clock edge, the command is ignored: `cmd_o` is 0 and bank state does not change.
- R11: At the first edge where `cke_i` is low after being high, `pd_mode_o` becomes 2 if any bank is active and 1 if all banks are idle. It holds that value while `cke_i` stays low and returns to 0 at the first edge where `cke_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every input is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address bus; bit 10 is the precharge and auto-precharge qualifier |
| cmd_o | output | 3 | Decoded command code (R3) |
| bank_o | output | 2 | Bank targeted by the command |
| auto_pre_o | output | 1 | Auto-precharge flag of a read or write |
| col_o | output | 12 | Column address of the last read or write |
| mrs_ext_o | output | 1 | Last mode-register load was aimed at the extended register |
| opcode_o | output | 13 | Opcode of the last mode-register load |
| bank_active_o | output | 4 | Per-bank active flag |
| open_row_o | output | 52 | Open row of each bank, 13 bits per bank |
| violation_o | output | 1 | Sticky protocol-violation flag |
| pd_mode_o | output | 2 | Power-down mode: 0 none, 1 precharge, 2 active |

## Verification
The assertions assume that every input is stable across the rising edge and that reset is released with `cke_i` at a known level. They make no assumption about the order of commands, because illegal orders are part of the behaviour being checked. The stimulus changes every input only on the falling edge. It walks all sixteen strobe combinations against every bank with bit 10 both low and high, which produces legal and illegal orders on purpose. Separate directed sequences cover clock-enable drops with active banks and with idle banks.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PD_NONE = 2'd0,
    PD_PRE  = 2'd1,
    PD_ACT  = 2'd2
  } pd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  localparam int COL_W = ADDR_W - 1
) (
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output cmd_e              cmd_o,
  output logic              ap_o,
  output logic [COL_W-1:0]  col_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = addr_i[AP_BIT] ? CMD_PREA : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

  assign ap_o = addr_i[AP_BIT];

  // column = address with the qualifier bit squeezed out
  for (genvar g = 0; g < COL_W; g++) begin : g_col
    if (g < AP_BIT) begin : g_lo
      assign col_o[g] = addr_i[g];
    end else begin : g_hi
      assign col_o[g] = addr_i[g+1];
    end
  end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end else if (open_i) begin
      active_o <= 1'b1;
      row_o    <= row_i;
    end else if (close_i) begin
      active_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  cmd_e                       cmd_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic                       ap_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NUM_BANKS-1:0]       active_o,
  output logic [NUM_BANKS*ROW_W-1:0] rows_o,
  output logic                       viol_o,
  output logic                       any_active_o
);

  logic is_col;
  logic sel_active;
  logic bad;

  assign is_col     = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign sel_active = active_o[ba_i];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit, open_b, close_b;
    assign hit     = en_i && (ba_i == BA_W'(g));
    assign open_b  = hit && (cmd_i == CMD_ACT) && !active_o[g];
    assign close_b = (en_i && (cmd_i == CMD_PREA)) ||
                     (hit && ((cmd_i == CMD_PRE) || (is_col && ap_i)));

    sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .open_i  (open_b),
      .close_i (close_b),
      .row_i   (row_i),
      .active_o(active_o[g]),
      .row_o   (rows_o[g*ROW_W +: ROW_W])
    );
  end

  assign bad = en_i && (((cmd_i == CMD_ACT) && sel_active) ||
                        (is_col && !sel_active));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  viol_o <= 1'b0;
    else if (bad) viol_o <= 1'b1;
  end

  assign any_active_o = |active_o;

endmodule

// File: rtl/sdram_pd_classify.sv
module sdram_pd_classify
  import sdram_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic any_active_i,
  output pd_e  pd_o
);

  logic cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b1;
      pd_o  <= PD_NONE;
    end else begin
      cke_q <= cke_i;
      if (cke_i)       pd_o <= PD_NONE;
      else if (cke_q)  pd_o <= any_active_i ? PD_ACT : PD_PRE;
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int COL_W    = ADDR_W - 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cke_i,
  input  logic                        cs_ni,
  input  logic                        ras_ni,
  input  logic                        cas_ni,
  input  logic                        we_ni,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [2:0]                  cmd_o,
  output logic [BA_W-1:0]             bank_o,
  output logic                        auto_pre_o,
  output logic [COL_W-1:0]            col_o,
  output logic                        mrs_ext_o,
  output logic [ADDR_W-1:0]           opcode_o,
  output logic [NUM_BANKS-1:0]        bank_active_o,
  output logic [NUM_BANKS*ADDR_W-1:0] open_row_o,
  output logic                        violation_o,
  output logic [1:0]                  pd_mode_o
);

  cmd_e             dec_cmd, cmd_eff;
  logic             dec_ap;
  logic [COL_W-1:0] dec_col;
  logic             any_active;
  pd_e              pd_mode;
  logic             banked, is_col;

  sdram_cmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .addr_i(addr_i),
    .cmd_o (dec_cmd),
    .ap_o  (dec_ap),
    .col_o (dec_col)
  );

  assign cmd_eff = cke_i ? dec_cmd : CMD_NOP;
  assign is_col  = (cmd_eff == CMD_RD) || (cmd_eff == CMD_WR);
  assign banked  = is_col || (cmd_eff == CMD_ACT) || (cmd_eff == CMD_PRE);

  sdram_bank_tracker #(.NUM_BANKS(NUM_BANKS), .ROW_W(ADDR_W)) u_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (cke_i),
    .cmd_i       (cmd_eff),
    .ba_i        (ba_i),
    .ap_i        (dec_ap),
    .row_i       (addr_i),
    .active_o    (bank_active_o),
    .rows_o      (open_row_o),
    .viol_o      (violation_o),
    .any_active_o(any_active)
  );

  sdram_pd_classify u_pd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cke_i       (cke_i),
    .any_active_i(any_active),
    .pd_o        (pd_mode)
  );

  assign pd_mode_o = pd_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= CMD_NOP;
      bank_o     <= '0;
      auto_pre_o <= 1'b0;
      col_o      <= '0;
      mrs_ext_o  <= 1'b0;
      opcode_o   <= '0;
    end else begin
      cmd_o      <= cmd_eff;
      bank_o     <= banked ? ba_i : '0;
      auto_pre_o <= is_col && dec_ap;
      if (is_col) col_o <= dec_col;
      if (cmd_eff == CMD_MRS) begin
        opcode_o  <= addr_i;
        mrs_ext_o <= (ba_i == BA_W'(1));
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cke_i,
  input logic                 cs_ni,
  input logic [2:0]           cmd_o,
  input logic [BA_W-1:0]      bank_o,
  input logic                 auto_pre_o,
  input logic [NUM_BANKS-1:0] bank_active_o,
  input logic                 violation_o,
  input logic [1:0]           pd_mode_o
);

  // R2
  cs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cs_ni) |=> (cmd_o == 3'(CMD_NOP)));

  // R5
  act_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'(CMD_ACT)) |-> bank_active_o[bank_o]);

  // R6
  prea_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'(CMD_PREA)) |-> (bank_active_o == '0));

  // R7
  ap_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cmd_o == 3'(CMD_RD)) || (cmd_o == 3'(CMD_WR))) && auto_pre_o)
      |-> !bank_active_o[bank_o]);

  // R9
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |=> violation_o);

  // R10
  cke_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> ($stable(bank_active_o) && (cmd_o == 3'(CMD_NOP))));

  // R11
  pd_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (pd_mode_o != 2'(PD_NONE)));

  // R11
  pd_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> (pd_mode_o == 2'(PD_NONE)));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cke_i        (cke_i),
  .cs_ni        (cs_ni),
  .cmd_o        (cmd_o),
  .bank_o       (bank_o),
  .auto_pre_o   (auto_pre_o),
  .bank_active_o(bank_active_o),
  .violation_o  (violation_o),
  .pd_mode_o    (pd_mode_o)
);

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_i = 1'b1;
  logic        cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [1:0]  ba_i = '0;
  logic [12:0] addr_i = '0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic        auto_pre_o;
  logic [11:0] col_o;
  logic        mrs_ext_o;
  logic [12:0] opcode_o;
  logic [3:0]  bank_active_o;
  logic [51:0] open_row_o;
  logic        violation_o;
  logic [1:0]  pd_mode_o;

  int checks = 0;
  int failures = 0;

  // bench model
  bit        m_act [4];
  bit [12:0] m_row [4];
  bit        m_viol, m_ext, m_ap, m_cke_prev;
  bit [11:0] m_col;
  bit [12:0] m_op;
  int        m_cmd, m_bank, m_pd;

  always #10 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i),
    .addr_i(addr_i), .cmd_o(cmd_o), .bank_o(bank_o),
    .auto_pre_o(auto_pre_o), .col_o(col_o), .mrs_ext_o(mrs_ext_o),
    .opcode_o(opcode_o), .bank_active_o(bank_active_o),
    .open_row_o(open_row_o), .violation_o(violation_o),
    .pd_mode_o(pd_mode_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dec(input logic [3:0] ctl, input logic a10);
    if (ctl[3]) return 0;
    case (ctl[2:0])
      3'b011:  return 1;
      3'b101:  return 2;
      3'b100:  return 3;
      3'b010:  return a10 ? 5 : 4;
      3'b001:  return 6;
      3'b000:  return 7;
      default: return 0;
    endcase
  endfunction

  task automatic model(input logic cke, input logic [3:0] ctl,
                       input logic [1:0] ba, input logic [12:0] addr);
    bit any;
    int c;
    any = m_act[0] | m_act[1] | m_act[2] | m_act[3];
    c = cke ? dec(ctl, addr[10]) : 0;
    m_cmd  = c;
    m_bank = (c >= 1 && c <= 4) ? int'(ba) : 0;
    m_ap   = (c == 2 || c == 3) && addr[10];
    case (c)
      1: if (m_act[ba]) m_viol = 1; else begin m_act[ba] = 1; m_row[ba] = addr; end
      2, 3: begin
        m_col = 12'(((addr >> 11) << 10) | (addr & 13'h3FF));
        if (!m_act[ba]) m_viol = 1;
        else if (addr[10]) m_act[ba] = 0;
      end
      4: m_act[ba] = 0;
      5: for (int i = 0; i < 4; i++) m_act[i] = 0;
      7: begin m_op = addr; m_ext = (ba == 2'd1); end
      default: ;
    endcase
    if (cke) m_pd = 0;
    else if (m_cke_prev) m_pd = any ? 2 : 1;
    m_cke_prev = cke;
  endtask

  task automatic verify(input string tag);
    chk(cmd_o == 3'(m_cmd), {tag, " R3 cmd"}, 64'(cmd_o), 64'(m_cmd));
    chk(bank_o == 2'(m_bank), {tag, " R4 bank"}, 64'(bank_o), 64'(m_bank));
    chk(auto_pre_o == m_ap, {tag, " R7 auto_pre"}, 64'(auto_pre_o), 64'(m_ap));
    chk(col_o == m_col, {tag, " R7 col"}, 64'(col_o), 64'(m_col));
    chk(opcode_o == m_op && mrs_ext_o == m_ext, {tag, " R8 mrs"},
        64'({mrs_ext_o, opcode_o}), 64'({m_ext, m_op}));
    chk(bank_active_o == {m_act[3], m_act[2], m_act[1], m_act[0]},
        {tag, " R6 active"}, 64'(bank_active_o),
        64'({m_act[3], m_act[2], m_act[1], m_act[0]}));
    for (int i = 0; i < 4; i++)
      if (m_act[i])
        chk(open_row_o[i*13 +: 13] == m_row[i], {tag, " R5 row"},
            64'(open_row_o[i*13 +: 13]), 64'(m_row[i]));
    chk(violation_o == m_viol, {tag, " R9 viol"}, 64'(violation_o), 64'(m_viol));
    chk(pd_mode_o == 2'(m_pd), {tag, " R11 pd"}, 64'(pd_mode_o), 64'(m_pd));
  endtask

  task automatic step(input string tag, input logic cke, input logic [3:0] ctl,
                      input logic [1:0] ba, input logic [12:0] addr);
    cke_i = cke;
    {cs_ni, ras_ni, cas_ni, we_ni} = ctl;
    ba_i = ba;
    addr_i = addr;
    @(posedge clk);
    model(cke, ctl, ba, addr);
    @(negedge clk);
    verify(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    cke_i = 1'b1;
    {cs_ni, ras_ni, cas_ni, we_ni} = 4'b1111;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_row[i] = 0; end
    m_viol = 0; m_ext = 0; m_ap = 0; m_cke_prev = 1; m_col = 0; m_op = 0;
    m_cmd = 0; m_bank = 0; m_pd = 0;
    verify("R1 reset");
    chk(open_row_o == '0, "R1 rows zero", 64'(open_row_o[12:0]), 64'(0));
    rst_ni = 1'b1;
  endtask

  localparam logic [3:0] ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100;
  localparam logic [3:0] PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam logic [3:0] NOP = 4'b0111;

  initial begin
    do_reset();
    @(negedge clk);
    // legal traffic (R5, R6, R7, R8)
    for (int b = 0; b < 4; b++) step("R5 open", 1, ACT, 2'(b), 13'(16'h0123 + b * 16'h0345));
    step("R7 read", 1, RD, 2'd1, 13'h1BFF);
    step("R7 write ap", 1, WR, 2'd2, 13'h0C21);
    step("R6 pre one", 1, PRE, 2'd0, 13'h0000);
    step("R8 mrs base", 1, MRS, 2'd0, 13'h0062);
    step("R8 mrs ext", 1, MRS, 2'd1, 13'h1001);
    step("R3 refresh", 1, REF, 2'd0, 13'h0);
    step("R3 nop", 1, NOP, 2'd0, 13'h0);
    // R2: chip select high masks an activate
    step("R2 cs mask", 1, 4'b1011, 2'd0, 13'h0777);
    // R10/R11: clock enable low with banks open, command ignored
    step("R11 act pd", 0, ACT, 2'd0, 13'h0555);
    step("R10 ignore", 0, PRE, 2'd1, 13'h0400);
    step("R11 exit", 1, NOP, 2'd0, 13'h0);
    step("R6 pre all", 1, PRE, 2'd3, 13'h0400);
    step("R11 pre pd", 0, NOP, 2'd0, 13'h0);
    step("R11 hold", 0, ACT, 2'd2, 13'h0);
    step("R11 exit2", 1, NOP, 2'd0, 13'h0);
    chk(violation_o == 1'b0, "R9 clean traffic", 64'(violation_o), 64'(0));
    // sweep all strobe codes x banks x bit 10 (R2, R3, R4, R9)
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 2; a++) begin
          logic [12:0] ad;
          ad = 13'((c * 977 + b * 131 + a * 4096) & 32'h1FFF);
          ad[10] = a[0];
          step("sweep", 1, 4'(c), 2'(b), ad);
        end
    // sticky violation after fresh reset
    do_reset();
    @(negedge clk);
    step("R9 rd idle", 1, RD, 2'd3, 13'h0010);
    step("R9 sticky", 1, NOP, 2'd0, 13'h0);
    step("R9 act", 1, ACT, 2'd3, 13'h0ABC);
    step("R9 act again", 1, ACT, 2'd3, 13'h0DEF);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule